// File: doc/BRIEF.md
# Gated Programmable Clock Post-Divider

The block takes a fast input clock and derives a slower output waveform from it. The divide factor, 1 to 31, is set through a single-cycle write strobe. Everything runs in the input clock domain and every output comes from a register, so `div_out` is best treated as a registered clock or clock-enable signal. With factor 1 the output is high on every running cycle, which makes it a gated enable at the full input rate.

A new factor is not applied when it is written. It waits as a pending value and is loaded when the current output period completes, so no period is ever shortened. When the load happens, a read-only flag bit inverts. The output can stop automatically when the `demand` input from consumers goes low, or it can be forced to keep running. The gate opens and closes only at a period boundary, while the output is low. The actual gate state can be read back, together with the programmed factor and the force control, as one 32-bit word.

Top module: `pdiv_top`

## Requirements
- R1: After reset a read returns 0x0000_0001: factor field bits 6:0 = 1, bit 7 = 0, bit 8 = 0, bit 9 = 0. `div_out` is low.
- R2: With active factor N, a running output repeats every N input cycles. For N of 2 or more, each period starts with floor(N/2) high cycles and the rest of the period is low. For N = 1 the output is high on every running cycle.
- R3: A legal factor written in bits 6:0 does not take effect at once. It is loaded at the end of the output period in progress, and no period is shortened. If several writes arrive before a boundary, the last one is applied.
- R4: Bit 7 inverts once, at the boundary where a written factor becomes active. A write of the factor that is already active also inverts it.
- R5: A write whose bits 6:0 are 0 or greater than 31 leaves the factor field, the active factor and bit 7 unchanged. Bit 8 of that same write is still applied.
- R6: Bits 31:10 always read as 0, and writing ones to them has no effect.
- R7: With bit 8 = 0, the output runs only while `demand` is high. When `demand` drops, the current period finishes and the output then stays low. A stop never cuts a high phase short.
- R8: With bit 8 = 1, the output runs whether or not `demand` is high. Bit 8 takes effect one cycle after the write.
- R9: Bit 9 reads 1 while the output is running and 0 while it is gated. The gate changes only at a period boundary, and a restart always begins a fresh period with its high phase.
- R10: A read strobe in cycle k presents the register word on `rd_data` in cycle k+1, sampled at the edge of cycle k. Without a strobe, `rd_data` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 32 | Write word (bits 6:0 factor, bit 8 force) |
| rd_en | input | 1 | Single-cycle read strobe |
| rd_data | output | 32 | Registered read word |
| demand | input | 1 | Consumer request for the output clock |
| div_out | output | 1 | Divided, gated output |

## Verification
The bench builds the block with its default parameters: a 7-bit factor field and a maximum factor of 31. These defaults bring the longest legal period within reach. They also make both kinds of illegal write reachable: zero, and values such as 40 and 127 that fit in the field but exceed the limit. A behavioural model tracks the position within the period, the pending factor and the gate. It is compared with `div_out` and the read word on every cycle, across odd, even and unit factors, writes in the middle of a period, demand pulses as short as one cycle, and forced running.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
  // Positions inside the 32-bit register word
  localparam int unsigned FLAG_BIT  = 7;
  localparam int unsigned FORCE_BIT = 8;
  localparam int unsigned STAT_BIT  = 9;

  // Number of high cycles at the start of a period of length n
  function automatic int unsigned high_cycles(input int unsigned n);
    return (n <= 1) ? 1 : n / 2;
  endfunction
endpackage

// File: rtl/pdiv_regs.sv
module pdiv_regs #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DIV_W   = 7,
  parameter int unsigned DIV_MAX = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              flag_in,
  input  logic              run_in,
  output logic              ld_valid,
  output logic [DIV_W-1:0]  ld_value,
  output logic              force_q,
  output logic [DATA_W-1:0] rd_data
);
  import pdiv_pkg::*;

  logic [DIV_W-1:0]  field_q;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] word;
  logic              legal;

  // Only factors 1..DIV_MAX are accepted
  assign ld_value = wr_data[DIV_W-1:0];
  assign legal    = (ld_value != '0) && (int'(ld_value) <= int'(DIV_MAX));
  assign ld_valid = wr_en && legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      field_q <= DIV_W'(1);
      force_q <= 1'b0;
    end else if (wr_en) begin
      force_q <= wr_data[FORCE_BIT];
      if (legal) field_q <= ld_value;
    end
  end

  always_comb begin
    word                = '0;
    word[DIV_W-1:0]     = field_q;
    word[FLAG_BIT]      = flag_in;
    word[FORCE_BIT]     = force_q;
    word[STAT_BIT]      = run_in;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= word;
  end
  assign rd_data = rd_q;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_q[DATA_W-1:STAT_BIT+1] == '0);                                   // R6
  AST_FIELD_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (field_q != '0) && (int'(field_q) <= int'(DIV_MAX)));               // R5
  AST_BAD_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !legal) |=> $stable(field_q));                            // R5
endmodule

// File: rtl/pdiv_core.sv
module pdiv_core #(
  parameter int unsigned DIV_W   = 7,
  parameter int unsigned DIV_MAX = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_valid,
  input  logic [DIV_W-1:0] ld_value,
  input  logic             force_on,
  input  logic             demand,
  output logic             div_out,
  output logic             flag,
  output logic             running
);
  import pdiv_pkg::*;

  localparam int unsigned CNT_W = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

  logic             run_q, run_d;
  logic             flag_q, flag_d;
  logic             out_q, out_d;
  logic             pend_v_q, pend_v_d;
  logic [DIV_W-1:0] act_q, act_d;
  logic [DIV_W-1:0] pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             boundary;
  logic             want;

  assign want     = force_on || demand;
  assign boundary = !run_q || (int'(cnt_q) == int'(act_q) - 1);

  always_comb begin
    run_d    = run_q;
    cnt_d    = cnt_q + 1'b1;
    act_d    = act_q;
    pend_v_d = pend_v_q;
    pend_d   = pend_q;
    flag_d   = flag_q;
    if (boundary) begin
      run_d = want;
      cnt_d = '0;
      if (pend_v_q) begin
        act_d    = pend_q;
        pend_v_d = 1'b0;
        flag_d   = ~flag_q;
      end
    end
    if (ld_valid) begin
      pend_v_d = 1'b1;
      pend_d   = ld_value;
    end
    out_d = run_d && (int'(cnt_d) < int'(high_cycles(int'(act_d))));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      cnt_q    <= '0;
      act_q    <= DIV_W'(1);
      pend_v_q <= 1'b0;
      pend_q   <= DIV_W'(1);
      flag_q   <= 1'b0;
      out_q    <= 1'b0;
    end else begin
      run_q    <= run_d;
      cnt_q    <= cnt_d;
      act_q    <= act_d;
      pend_v_q <= pend_v_d;
      pend_q   <= pend_d;
      flag_q   <= flag_d;
      out_q    <= out_d;
    end
  end

  assign div_out = out_q;
  assign flag    = flag_q;
  assign running = run_q;

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) < int'(act_q));                                         // R3
  AST_ACT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (act_q != '0) && (int'(act_q) <= int'(DIV_MAX)));                   // R5
  AST_ACT_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_q) |-> (cnt_q == '0));                                 // R3
  AST_FLAG_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
    !$stable(flag_q) |-> (cnt_q == '0));                                // R4
  AST_GATE_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
    !$stable(run_q) |-> (cnt_q == '0));                                 // R9
  AST_NO_TRUNC_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(run_q) |-> (!$past(out_q) || ($past(act_q) == DIV_W'(1))));   // R7
  AST_GATED_LOW: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> !out_q);                                                 // R9
endmodule

// File: rtl/pdiv_top.sv
module pdiv_top #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DIV_W   = 7,
  parameter int unsigned DIV_MAX = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              demand,
  output logic              div_out
);
  logic             ld_valid;
  logic [DIV_W-1:0] ld_value;
  logic             force_q;
  logic             flag;
  logic             running;

  pdiv_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .DIV_MAX(DIV_MAX)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .flag_in  (flag),
    .run_in   (running),
    .ld_valid (ld_valid),
    .ld_value (ld_value),
    .force_q  (force_q),
    .rd_data  (rd_data)
  );

  pdiv_core #(.DIV_W(DIV_W), .DIV_MAX(DIV_MAX)) u_core (
    .clk      (clk),
    .rst      (rst),
    .ld_valid (ld_valid),
    .ld_value (ld_value),
    .force_on (force_q),
    .demand   (demand),
    .div_out  (div_out),
    .flag     (flag),
    .running  (running)
  );

  AST_FORCE_KEEPS_RUN: assert property (@(posedge clk) disable iff (rst)
    (force_q && running) |=> running);                                  // R8
endmodule

// File: tb/tb_pdiv_top.sv
module tb_pdiv_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        demand = 1'b0;
  logic        div_out;

  always #4 clk = ~clk; // 125 MHz

  pdiv_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .demand(demand), .div_out(div_out)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // Behavioural reference: position in period, period length, pending value
  int   m_pos, m_len, m_pend;
  bit   m_run, m_flag, m_force, m_live;
  int   m_field;
  logic [31:0] m_rd;

  function automatic int highs(int n);
    return (n <= 1) ? 1 : n / 2;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pos = 0; m_len = 1; m_pend = 0; m_run = 0; m_flag = 0;
      m_force = 0; m_field = 1; m_rd = '0; m_live = 0;
    end else begin
      bit last;
      m_live = 1;
      if (rd_en) begin // R10: word sampled before this edge's updates
        m_rd = '0;
        m_rd[6:0] = m_field[6:0];
        m_rd[7] = m_flag;
        m_rd[8] = m_force;
        m_rd[9] = m_run;
      end
      last = !m_run || (m_pos == m_len - 1);
      if (last) begin
        m_run = m_force || demand; // R7 R8: registered force, live demand
        m_pos = 0;
        if (m_pend > 0) begin       // R3 R4
          m_len = m_pend; m_pend = 0; m_flag = !m_flag;
        end
      end else m_pos++;
      if (wr_en) begin
        m_force = wr_data[8];
        if (wr_data[6:0] >= 1 && wr_data[6:0] <= 31) begin // R5
          m_pend = int'(wr_data[6:0]);
          m_field = int'(wr_data[6:0]);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (m_live && !done) begin
      bit exp_out;
      exp_out = m_run && (m_pos < highs(m_len)); // R2
      checks++;
      if (div_out !== exp_out) begin
        errors++;
        $display("FAIL %s div_out actual=%b expected=%b t=%0t", cur_req, div_out, exp_out, $time);
      end
      checks++;
      if (rd_data !== m_rd) begin
        errors++;
        $display("FAIL %s rd_data actual=%h expected=%h t=%0t", cur_req, rd_data, m_rd, $time);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0; rd_en = 1'b1;
    cur_req = "R1"; idle(4);                       // R1 reset word 0x001
    cur_req = "R2"; demand = 1'b1; idle(8);        // R2 factor 1
    wr(32'd4);  idle(20);
    wr(32'd7);  idle(30);
    wr(32'd2);  idle(10);
    wr(32'd31); idle(70);
    cur_req = "R3"; wr(32'd9); idle(3); wr(32'd5); idle(2); wr(32'd6); idle(25);
    wr(32'd11); idle(4); wr(32'd3); idle(20);      // R3 last write wins
    cur_req = "R4"; wr(32'd3); idle(8); wr(32'd3); idle(8); // R4 same value
    cur_req = "R5"; wr(32'd0); idle(10);           // R5 zero ignored
    wr(32'h0000_0128); idle(10);                   // R5 40 ignored, force set
    wr(32'h0000_007F); idle(10);                   // R5 127 ignored, force clear
    cur_req = "R6"; wr(32'hFFFF_FC05); idle(15);   // R6 upper bits dropped
    cur_req = "R7"; demand = 1'b0; idle(12);
    demand = 1'b1; idle(1); demand = 1'b0; idle(12);
    wr(32'd1); demand = 1'b1; idle(5); demand = 1'b0; idle(5);
    wr(32'd8); demand = 1'b1; idle(3); demand = 1'b0; idle(14);
    cur_req = "R8"; wr(32'h0000_0105); idle(20); wr(32'd5); idle(15);
    cur_req = "R9"; demand = 1'b1; idle(6); demand = 1'b0; idle(10);
    demand = 1'b1; wr(32'd4); idle(9);
    cur_req = "R10"; rd_en = 1'b0; idle(5); wr(32'd3); idle(5);
    rd_en = 1'b1; idle(1); rd_en = 1'b0; idle(4); rd_en = 1'b1; idle(4);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule